// File: doc/BRIEF.md
# Four-Pixel Regional Hit Buffer

This block is the shared digital logic for a cluster of four neighbouring pixels in a hybrid pixel readout array. Each pixel's discriminator output is measured as a time-over-threshold (ToT) in bunch-crossing clock cycles. Hits stay inside the region until the trigger decision is due, rather than being moved down the column straight away. A hit at or above a programmable small-hit threshold takes one of a small pool of storage slots and starts that slot's latency countdown. A hit below the threshold gets no time slot of its own. It is written into the slot of a large hit in the region, so it is tied to that hit by position and not by its own timestamp.

When a slot's countdown reaches its end, the slot survives only if the level-1 trigger input is high in that very cycle; otherwise it is released. Surviving slots are queued in allocation order. The head slot is presented on a read port carrying all four ToT nibbles and a valid flag. The region joins a column-wide token chain: it holds the token while it has data, and it passes the token on when it has none. A new large hit that finds every slot busy is dropped and flagged for one cycle.

Every clock edge is one bunch crossing. The latency and threshold inputs are assumed static while hits are in flight.

Top module: `quad_pixel_region`

## Requirements
- R1: A pixel's ToT equals the number of clock edges at which its discriminator was sampled high, saturating at 14 (4'hE). In `rd_tot`, pixel p occupies bits [4p+3:4p], with pixel 0 top-left, 1 top-right, 2 bottom-left and 3 bottom-right, and 4'hF means that pixel has no hit.
- R2: A hit completes in the cycle after its discriminator falls. If any completing hit has ToT >= `small_thr`, a single slot is allocated at the next edge, and it stores every pixel that completes in that cycle, small hits included.
- R3: A small hit that completes when no large hit completes is written into the slot allocated at the immediately preceding edge, if that slot's field for its pixel is still 4'hF. In every other case the small hit is discarded and never appears on the read port.
- R4: A slot allocated at edge A samples `trig` at edge A+latency+1. If `trig` is high there, the slot is queued for readout; a trigger at any other edge has no effect on it, and the slot is freed.
- R5: When a large hit completes while all slots are busy, `ovf` is high during that cycle and the hit is lost. Hits already stored are unaffected. `ovf` is low in every other cycle.
- R6: While `rd_valid` is high, `rd_tot` shows the head queued slot and holds steady. At an edge where `rd_valid`, `token_in` and `rd_req` are all high, that slot is freed and the queue advances.
- R7: Queued slots appear on the read port in the order in which they were allocated.
- R8: `token_out` is high exactly when `token_in` is high and `rd_valid` is low.
- R9: After reset, every slot is free, `rd_valid` and `ovf` are low, and `token_out` follows `token_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc | input | 4 | Discriminator outputs, bit p for pixel p |
| latency | input | 8 | Trigger latency in clock cycles |
| small_thr | input | 4 | ToT below which a hit counts as small |
| trig | input | 1 | Level-1 trigger |
| token_in | input | 1 | Read token from the preceding region |
| rd_req | input | 1 | Column read strobe |
| token_out | output | 1 | Read token passed to the next region |
| rd_valid | output | 1 | A triggered slot is on the read port |
| rd_tot | output | 16 | Four ToT nibbles of the head slot |
| ovf | output | 1 | Large hit lost because all slots are busy |

## Verification
A wrong ToT counter or a mis-steered small hit shows up as a wrong nibble on `rd_tot`, one latency period after the event, when the slot is read. An off-by-one in the latency countdown moves the first high cycle of `rd_valid` by one cycle, and it makes a trigger placed exactly on the expiry edge miss. Corrupted slot bookkeeping is seen as an early or missing `ovf` once the pool is full, as a hit that never surfaces, or as reads that arrive out of order. All of these appear within a few latency periods of the stimulus.

// File: rtl/qpr_pkg.sv
// Shared constants and types for the four-pixel regional hit buffer.
// Assumes four pixels per region and 4-bit ToT codes.
package qpr_pkg;
    localparam int NPIX     = 4;
    localparam int TOTW     = 4;
    localparam logic [TOTW-1:0] TOT_NONE = 4'hF;
    localparam logic [TOTW-1:0] TOT_SAT  = 4'hE;

    typedef logic [TOTW-1:0] tot_t;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_TRIG = 2'd2
    } slot_st_e;
endpackage

// File: rtl/qpr_tot_meas.sv
// Per-pixel ToT meter: counts the clock edges at which the discriminator
// is high, saturating at TOT_SAT. done pulses in the cycle after the
// discriminator falls, with tot holding the final count.
// Assumes disc is synchronous to clk.
module qpr_tot_meas
    import qpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disc,
    output tot_t tot,
    output logic done
);
    logic disc_q;
    tot_t cnt;

    // Track the previous discriminator level and count the high edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disc_q <= 1'b0;
            cnt    <= '0;
        end else begin
            disc_q <= disc;
            if (disc) begin
                if (!disc_q)
                    cnt <= tot_t'(1);
                else if (cnt != TOT_SAT)
                    cnt <= cnt + tot_t'(1);
            end
        end
    end

    assign done = disc_q & ~disc;
    assign tot  = cnt;
endmodule

// File: rtl/qpr_pick_lowest.sv
// Priority encoder: returns the index of the lowest set request bit and
// a flag telling whether any bit is set.
// Assumes IW is wide enough to hold N-1.
module qpr_pick_lowest #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so that the lowest request is the last one written.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/qpr_read_fifo.sv
// Small queue of slot indices kept in trigger order. It never holds more
// than DEPTH entries, because each entry stands for one busy slot.
// Assumes the push side cannot overfill it.
module qpr_read_fifo #(
    parameter int DEPTH = 5,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic          nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Store pushed indices; no reset is needed on the data.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_idx;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            if (push && !pop)
                count <= count + CW'(1);
            else if (pop && !push)
                count <= count - CW'(1);
        end
    end

    assign head_idx = mem[rd_ptr];
    assign nonempty = (count != '0);
endmodule

// File: rtl/quad_pixel_region.sv
// Four-pixel regional hit buffer. It measures ToT per pixel, stores large
// hits (with the small hits that go with them) in NSLOT latency slots,
// keeps the slots whose expiry meets a trigger, and offers them to the
// column through a token read port, in allocation order.
// Assumes latency and small_thr are static while hits are in flight, so
// that at most one slot expires per cycle.
module quad_pixel_region
    import qpr_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int LATW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPIX-1:0]      disc,
    input  logic [LATW-1:0]      latency,
    input  logic [TOTW-1:0]      small_thr,
    input  logic                 trig,
    input  logic                 token_in,
    input  logic                 rd_req,
    output logic                 token_out,
    output logic                 rd_valid,
    output logic [NPIX*TOTW-1:0] rd_tot,
    output logic                 ovf
);
    localparam int SIW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    tot_t            pix_tot [NPIX];
    logic [NPIX-1:0] pix_done, pix_big, pix_small, join_v;
    logic            any_big, have_free, do_alloc, push, rd_fire;
    logic [SIW-1:0]  alloc_idx, push_idx, head_idx, prev_idx;
    logic            prev_v;

    logic [NSLOT-1:0] slot_free, slot_busy, slot_trig, slot_expire;
    logic [NSLOT-1:0][NPIX*TOTW-1:0] slot_tot;

    // One ToT meter per pixel, classified against the small-hit threshold.
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        qpr_tot_meas u_tot (
            .clk  (clk),
            .rst_n(rst_n),
            .disc (disc[p]),
            .tot  (pix_tot[p]),
            .done (pix_done[p])
        );
        assign pix_big[p]   = pix_done[p] && (pix_tot[p] >= small_thr);
        assign pix_small[p] = pix_done[p] && !pix_big[p];
        assign join_v[p]    = pix_small[p] && !any_big && prev_v;
    end

    assign any_big  = |pix_big;
    assign do_alloc = any_big && have_free;
    assign ovf      = any_big && !have_free;

    qpr_pick_lowest #(.N(NSLOT), .IW(SIW)) u_alloc_pick (
        .req(slot_free),
        .idx(alloc_idx),
        .any(have_free)
    );

    qpr_pick_lowest #(.N(NSLOT), .IW(SIW)) u_expire_pick (
        .req(slot_expire),
        .idx(push_idx),
        .any(push)
    );

    qpr_read_fifo #(.DEPTH(NSLOT), .IW(SIW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_idx(push_idx),
        .pop     (rd_fire),
        .head_idx(head_idx),
        .nonempty(rd_valid)
    );

    // Remember which slot was allocated at the last edge, for late small hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v   <= 1'b0;
            prev_idx <= '0;
        end else begin
            prev_v   <= do_alloc;
            prev_idx <= alloc_idx;
        end
    end

    // Slot pool: state, latency countdown and four stored ToT nibbles each.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_st_e                  st_r;
        logic [LATW-1:0]           cnt_r;
        logic [NPIX-1:0][TOTW-1:0] tot_r;
        logic                      mine;

        assign mine = do_alloc && (alloc_idx == SIW'(s));

        // Allocate, count down, resolve the trigger, release on read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= SLOT_FREE;
                cnt_r <= '0;
                for (int p = 0; p < NPIX; p++)
                    tot_r[p] <= TOT_NONE;
            end else if (mine) begin
                st_r  <= SLOT_WAIT;
                cnt_r <= latency;
                for (int p = 0; p < NPIX; p++)
                    tot_r[p] <= pix_done[p] ? pix_tot[p] : TOT_NONE;
            end else begin
                case (st_r)
                    SLOT_WAIT: begin
                        if (cnt_r == '0)
                            st_r <= trig ? SLOT_TRIG : SLOT_FREE;
                        else
                            cnt_r <= cnt_r - LATW'(1);
                    end
                    SLOT_TRIG: begin
                        if (rd_fire && (head_idx == SIW'(s)))
                            st_r <= SLOT_FREE;
                    end
                    default: ;
                endcase
                for (int p = 0; p < NPIX; p++)
                    if (join_v[p] && (prev_idx == SIW'(s)) && (tot_r[p] == TOT_NONE))
                        tot_r[p] <= pix_tot[p];
            end
        end

        assign slot_free[s]   = (st_r == SLOT_FREE);
        assign slot_busy[s]   = (st_r != SLOT_FREE);
        assign slot_trig[s]   = (st_r == SLOT_TRIG);
        assign slot_expire[s] = (st_r == SLOT_WAIT) && (cnt_r == '0) && trig && !mine;
        assign slot_tot[s]    = tot_r;
    end

    assign rd_fire   = rd_valid && token_in && rd_req;
    assign rd_tot    = slot_tot[head_idx];
    assign token_out = token_in && !rd_valid;
endmodule

// File: rtl/quad_pixel_region_chk.sv
// Assertion checker for quad_pixel_region, attached by bind below.
// Assumes the internal vectors slot_busy and slot_trig of the top module.
module quad_pixel_region_chk
    import qpr_pkg::*;
#(
    parameter int NSLOT = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 token_in,
    input logic                 rd_req,
    input logic                 token_out,
    input logic                 rd_valid,
    input logic [NPIX*TOTW-1:0] rd_tot,
    input logic                 ovf,
    input logic [NSLOT-1:0]     slot_busy,
    input logic [NSLOT-1:0]     slot_trig
);
    // R6
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !(token_in && rd_req) |=> rd_valid && $stable(rd_tot));

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && token_in && rd_req |=> $countones(slot_trig) <= $past($countones(slot_trig)));

    // R5
    no_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (&slot_busy));

    // R8
    token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !token_out);

    // R1
    tot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_tot[3:0] != 4'h0) && (rd_tot[7:4] != 4'h0) &&
                     (rd_tot[11:8] != 4'h0) && (rd_tot[15:12] != 4'h0) &&
                     (rd_tot != 16'hFFFF));
endmodule

bind quad_pixel_region quad_pixel_region_chk #(.NSLOT(NSLOT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .token_in (token_in),
    .rd_req   (rd_req),
    .token_out(token_out),
    .rd_valid (rd_valid),
    .rd_tot   (rd_tot),
    .ovf      (ovf),
    .slot_busy(slot_busy),
    .slot_trig(slot_trig)
);

// File: tb/quad_pixel_region_test.sv
// Self-checking bench: sweeps ToT lengths and latencies, then covers
// grouping, late small hits, trigger timing, the token and overflow.
module quad_pixel_region_test;
    localparam int CLK_PERIOD = 10;

    typedef int quad_t [4];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  disc = '0;
    logic [7:0]  latency = 8'd2;
    logic [3:0]  small_thr = 4'd1;
    logic        trig = 1'b0;
    logic        token_in = 1'b0;
    logic        rd_req = 1'b0;
    logic        token_out, rd_valid, ovf;
    logic [15:0] rd_tot;

    int n_chk = 0;
    int n_fail = 0;

    quad_pixel_region uut (
        .clk(clk), .rst_n(rst_n), .disc(disc), .latency(latency),
        .small_thr(small_thr), .trig(trig), .token_in(token_in),
        .rd_req(rd_req), .token_out(token_out), .rd_valid(rd_valid),
        .rd_tot(rd_tot), .ovf(ovf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_tot(input int n);
        if (n <= 0) return 4'hF;
        if (n >= 14) return 4'hE;
        return 4'(n);
    endfunction

    function automatic logic [15:0] pack4(input int a, input int b, input int c, input int d);
        return {exp_tot(d), exp_tot(c), exp_tot(b), exp_tot(a)};
    endfunction

    // Pixel p is high for cycles fr[p] .. to[p]-1; returns just after the
    // negedge on which the longest pulse ends (its done is then visible).
    task automatic wave(input quad_t fr, input quad_t to);
        int len = 0;
        for (int p = 0; p < 4; p++) if (to[p] > len) len = to[p];
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            for (int p = 0; p < 4; p++) disc[p] = (c >= fr[p]) && (c < to[p]);
        end
        @(negedge clk);
        disc = '0;
        #1;
    endtask

    task automatic expect_read(input logic [15:0] exp, input string req);
        int w = 0;
        while (!rd_valid && w < 80) begin
            @(negedge clk); #1; w++;
        end
        chk(rd_valid == 1'b1, req, 32'(rd_valid), 32'd1);
        chk(rd_tot == exp, req, 32'(rd_tot), 32'(exp));
        token_in = 1'b1;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        #1;
    endtask

    task automatic expect_none(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (rd_valid) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        // R9: reset state
        token_in = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R9", 32'(rd_valid), 32'd0);
        chk(ovf == 1'b0, "R9", 32'(ovf), 32'd0);
        chk(token_out == 1'b1, "R9", 32'(token_out), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R4: ToT sweep across pixels and latencies, with exact valid timing
        trig = 1'b1;
        small_thr = 4'd1;
        for (int n = 1; n <= 16; n++) begin
            automatic int p = n % 4;
            automatic int lat = n % 4;
            automatic quad_t fr = '{0, 0, 0, 0};
            automatic quad_t to = '{0, 0, 0, 0};
            automatic int tl[4] = '{0, 0, 0, 0};
            latency = 8'(lat);
            to[p] = n;
            tl[p] = n;
            wave(fr, to);
            repeat (lat + 1) @(negedge clk);
            #1;
            chk(rd_valid == 1'b0, "R4", 32'(rd_valid), 32'd0);
            @(negedge clk); #1;
            chk(rd_valid == 1'b1, "R4", 32'(rd_valid), 32'd1);
            chk(rd_tot == pack4(tl[0], tl[1], tl[2], tl[3]), "R1", 32'(rd_tot),
                32'(pack4(tl[0], tl[1], tl[2], tl[3])));
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            #1;
            chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 32'd0);
        end

        // R2: mixed hits completing together share one slot
        latency = 8'd2;
        small_thr = 4'd3;
        wave('{2, 4, 0, 0}, '{5, 5, 0, 5});
        chk(ovf == 1'b0, "R2", 32'(ovf), 32'd0);
        expect_read(pack4(3, 1, 0, 5), "R2");
        expect_none("R2");

        // R3: a lone small hit is discarded
        wave('{0, 0, 0, 0}, '{0, 0, 2, 0});
        expect_none("R3");

        // R3: a small hit one cycle late joins the large hit's slot
        small_thr = 4'd4;
        wave('{0, 4, 0, 0}, '{5, 6, 0, 0});
        expect_read(pack4(5, 2, 0, 0), "R3");
        // R3: two cycles late it is dropped
        wave('{0, 5, 0, 0}, '{5, 7, 0, 0});
        expect_read(pack4(5, 0, 0, 0), "R3");
        expect_none("R3");

        // R4: only a trigger on the expiry edge keeps the slot
        small_thr = 4'd1;
        latency = 8'd5;
        trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            automatic int j = (k == 0) ? 5 : (k == 1) ? 7 : 6;
            wave('{0, 0, 0, 0}, '{0, 3, 0, 0});
            repeat (j) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            #1;
            if (j == 6) expect_read(pack4(0, 3, 0, 0), "R4");
            else        expect_none("R4");
        end

        // R6 / R8: token handling and holding the head slot
        latency = 8'd1;
        trig = 1'b1;
        token_in = 1'b0;
        wave('{0, 0, 0, 0}, '{0, 0, 4, 0});
        repeat (4) @(negedge clk);
        #1;
        chk(rd_valid == 1'b1, "R6", 32'(rd_valid), 32'd1);
        rd_req = 1'b1;
        #1;
        chk(token_out == 1'b0, "R8", 32'(token_out), 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(rd_valid == 1'b1 && rd_tot == pack4(0, 0, 4, 0), "R6", 32'(rd_tot), 32'(pack4(0, 0, 4, 0)));
        end
        token_in = 1'b1;
        #1;
        chk(token_out == 1'b0, "R8", 32'(token_out), 32'd0);
        @(negedge clk); #1;
        chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 32'd0);
        chk(token_out == 1'b1, "R8", 32'(token_out), 32'd1);
        rd_req = 1'b0;
        token_in = 1'b0;
        #1;
        chk(token_out == 1'b0, "R8", 32'(token_out), 32'd0);

        // R5 / R7: fill all slots, lose one hit, read back in order
        latency = 8'd40;
        for (int k = 1; k <= 5; k++) begin
            automatic quad_t to = '{0, 0, 0, 0};
            to[(k - 1) % 4] = k;
            wave('{0, 0, 0, 0}, to);
            chk(ovf == 1'b0, "R5", 32'(ovf), 32'd0);
        end
        wave('{0, 0, 0, 0}, '{6, 0, 0, 0});
        chk(ovf == 1'b1, "R5", 32'(ovf), 32'd1);
        @(negedge clk); #1;
        chk(ovf == 1'b0, "R5", 32'(ovf), 32'd0);
        expect_read(pack4(1, 0, 0, 0), "R7");
        expect_read(pack4(0, 2, 0, 0), "R7");
        expect_read(pack4(0, 0, 3, 0), "R7");
        expect_read(pack4(0, 0, 0, 4), "R7");
        expect_read(pack4(5, 0, 0, 0), "R7");
        expect_none("R5");
        latency = 8'd3;
        wave('{0, 0, 0, 0}, '{0, 0, 0, 7});
        chk(ovf == 1'b0, "R5", 32'(ovf), 32'd0);
        expect_read(pack4(0, 0, 0, 7), "R5");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule